// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a burst of up to four beats. A burst starts with a load: the base address, the beat-ordering mode and the access type are captured together. Each later advance steps a two-bit beat count, and the two lowest address bits are rebuilt from the base's low bits and that count. The upper address bits come from the captured base and do not change during the burst.

Two orderings are offered. Linear order adds the beat count to the base's low bits, modulo four. Interleaved order XORs the beat count into them. Both wrap back to the base after four advances. A clock-hold input freezes all state on any edge where it is high. An advance does not depend on the access-type input, so a burst keeps its read or write type from start to end.

Top module: `burst_addr_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, `cur_addr` is 0, `acc_is_wr` is 0 and the captured order is linear.
- R2: A qualified edge (`clk_hold` = 0) with `adv` = 0 loads `base_addr`. From the next cycle `cur_addr` equals `base_addr` and the beat count is 0.
- R3: If `mode_ilv` = 0 at the load, then after n advances `cur_addr[1:0]` = (base[1:0] + n) mod 4.
- R4: If `mode_ilv` = 1 at the load, then after n advances `cur_addr[1:0]` = base[1:0] XOR (n mod 4).
- R5: The beat count wraps. The fourth advance after a load returns `cur_addr` to the base address, and the sequence then repeats.
- R6: `cur_addr[ADDR_W-1:2]` keeps the loaded base's upper bits on every advance, whatever `base_addr` is at that time.
- R7: `acc_is_wr` takes the value of `wr_req` at the load (1 = write, 0 = read). Advances keep it unchanged whatever `wr_req` is.
- R8: The order is captured at the load. Changing `mode_ilv` or `base_addr` during advances does not change the sequence.
- R9: An edge with `clk_hold` = 1 changes no state. `cur_addr` and `acc_is_wr` stay the same whatever `adv`, `mode_ilv`, `base_addr` and `wr_req` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_hold | input | 1 | 1 = ignore this edge and hold all state |
| adv | input | 1 | 0 = load a new burst, 1 = advance the beat |
| mode_ilv | input | 1 | Order sampled at the load: 0 linear, 1 interleaved |
| base_addr | input | ADDR_W | Base address sampled at the load |
| wr_req | input | 1 | Access type sampled at the load: 1 write, 0 read |
| cur_addr | output | ADDR_W | Address of the current beat |
| acc_is_wr | output | 1 | Access type of the current burst |

## Verification
The hardest situation to reach is a long burst in which the inputs that must be ignored keep changing. That means advances that wrap past the fourth beat while `mode_ilv`, `base_addr` and `wr_req` toggle, with hold cycles placed in between. The stimulus loads every low-bit base value in both orders. It then advances five to six times while driving the opposite mode, a different base and the inverted type on every advance. It also places hold edges that carry load and advance requests in the middle of a burst. A behavioural model in the bench compares `cur_addr` and `acc_is_wr` after every edge.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the burst address sequencer.
// Assumes: the operation taken on an edge is one of hold, load or advance.
package bsq_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } beat_order_e;

endpackage

// File: rtl/bsq_ctrl.sv
`timescale 1ns/1ps
// Module: bsq_ctrl
// Turns the clock-hold and load/advance inputs into one operation per edge.
// Assumes: hold has priority, so a held edge never loads or advances.
module bsq_ctrl
    import bsq_pkg::*;
(
    input  logic    clk_hold,
    input  logic    adv,
    output seq_op_e op
);

    // Pick the operation for this edge.
    always_comb begin
        if (clk_hold)
            op = OP_HOLD;
        else if (adv)
            op = OP_STEP;
        else
            op = OP_LOAD;
    end

endmodule

// File: rtl/bsq_beat_ctr.sv
`timescale 1ns/1ps
// Module: bsq_beat_ctr
// Beat counter. It clears on a load, increments on an advance and wraps modulo 2**BEAT_W.
// Assumes: the synchronous reset clears it; a hold keeps its value.
module bsq_beat_ctr
    import bsq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_e           op,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    // Update the beat count once per qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else begin
            case (op)
                OP_LOAD: beat <= '0;
                OP_STEP: beat <= beat + ONE;
                default: beat <= beat;
            endcase
        end
    end

endmodule

// File: rtl/bsq_burst_reg.sv
`timescale 1ns/1ps
// Module: bsq_burst_reg
// Captures the base address, the beat order and the access type at a burst start.
// Assumes: only a load changes these registers, so advances and holds leave them as they are.
module bsq_burst_reg
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_e           op,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              mode_in,
    input  logic              wr_in,
    output logic [ADDR_W-1:0] base_q,
    output beat_order_e       order_q,
    output logic              wr_q
);

    // Latch the burst context at a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_LINEAR;
            wr_q    <= 1'b0;
        end else if (op == OP_LOAD) begin
            base_q  <= base_in;
            order_q <= beat_order_e'(mode_in);
            wr_q    <= wr_in;
        end
    end

endmodule

// File: rtl/bsq_order_map.sv
`timescale 1ns/1ps
// Module: bsq_order_map
// Combines the base low bits with the beat count: a sum modulo 2**BEAT_W
// for linear order, a bitwise XOR for interleaved order.
// Assumes: both inputs are BEAT_W wide, so the sum wraps on its own.
module bsq_order_map
    import bsq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat,
    input  beat_order_e       order,
    output logic [BEAT_W-1:0] addr_lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Interleaved term built bit by bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign ilv_lo[i] = base_lo[i] ^ beat[i];
    end

    // Linear term: the sum wraps at the counter width.
    always_comb lin_lo = base_lo + beat;

    // Choose the term for the captured order.
    always_comb addr_lo = (order == ORD_XOR) ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
// Module: burst_addr_seq (top)
// Generates the address sequence for a burst of up to 2**BEAT_W beats from a loaded base.
// Assumes: synchronous active-low reset; clk_hold high freezes every register.
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_hold,
    input  logic              adv,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              acc_is_wr
);

    localparam int UP_W = ADDR_W - BEAT_W;

    seq_op_e           op;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base_q;
    beat_order_e       order_q;
    logic [BEAT_W-1:0] addr_lo;

    bsq_ctrl u_ctrl (
        .clk_hold (clk_hold),
        .adv      (adv),
        .op       (op)
    );

    bsq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .beat  (beat)
    );

    bsq_burst_reg #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .base_in (base_addr),
        .mode_in (mode_ilv),
        .wr_in   (wr_req),
        .base_q  (base_q),
        .order_q (order_q),
        .wr_q    (acc_is_wr)
    );

    bsq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .base_lo (base_q[BEAT_W-1:0]),
        .beat    (beat),
        .order   (order_q),
        .addr_lo (addr_lo)
    );

    // Join the fixed upper bits with the sequenced low bits.
    always_comb cur_addr = {base_q[ADDR_W-1 -: UP_W], addr_lo};

endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
// Module: burst_addr_seq_chk
// Checks the sequencer through its ports. It keeps its own copy of the order seen at the last load.
// Assumes: bound to every instance of burst_addr_seq.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_hold,
    input logic              adv,
    input logic              mode_ilv,
    input logic [ADDR_W-1:0] base_addr,
    input logic              wr_req,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              acc_is_wr
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    logic seen_ilv;

    // Record the order requested at the last load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_ilv <= 1'b0;
        else if (!clk_hold && !adv)
            seen_ilv <= mode_ilv;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0 && !acc_is_wr));

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && !adv) |=> (cur_addr == $past(base_addr) && acc_is_wr == $past(wr_req)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && adv && !seen_ilv) |=>
            (cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + ONE));

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && adv) |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));

    // R7
    type_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && adv) |=> $stable(acc_is_wr));

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |=> ($stable(cur_addr) && $stable(acc_is_wr)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_hold  (clk_hold),
    .adv       (adv),
    .mode_ilv  (mode_ilv),
    .base_addr (base_addr),
    .wr_req    (wr_req),
    .cur_addr  (cur_addr),
    .acc_is_wr (acc_is_wr)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model, compared with the outputs after every edge.
module burst_addr_seq_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_hold = 1'b0;
    logic          adv = 1'b0;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          acc_is_wr;

    int total = 0;
    int bad = 0;

    // Reference state.
    int m_base = 0;
    int m_beat = 0;
    int m_ilv  = 0;
    int m_wr   = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_hold  (clk_hold),
        .adv       (adv),
        .mode_ilv  (mode_ilv),
        .base_addr (base_addr),
        .wr_req    (wr_req),
        .cur_addr  (cur_addr),
        .acc_is_wr (acc_is_wr)
    );

    function automatic int exp_addr();
        int lo;
        lo = (m_ilv != 0) ? ((m_base % 4) ^ m_beat) : (((m_base % 4) + m_beat) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic compare(input string tag);
        total++;
        if (int'(cur_addr) != exp_addr() || int'(acc_is_wr) != m_wr) begin
            bad++;
            $display("FAIL %s: addr=%0h wr=%0d expected addr=%0h wr=%0d",
                     tag, cur_addr, acc_is_wr, exp_addr(), m_wr);
        end
    endtask

    // One clock edge: drive at negedge, update the model at posedge, compare 1 ns later.
    task automatic step(input logic r, input logic h, input logic a, input logic m,
                        input int b, input logic w, input string tag);
        @(negedge clk);
        rst_n = r; clk_hold = h; adv = a; mode_ilv = m;
        base_addr = AW'(b); wr_req = w;
        @(posedge clk);
        if (!r) begin
            m_base = 0; m_beat = 0; m_ilv = 0; m_wr = 0;
        end else if (!h) begin
            if (!a) begin
                m_base = b; m_beat = 0; m_ilv = int'(m); m_wr = int'(w);
            end else
                m_beat = (m_beat + 1) % 4;
        end
        #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: expired, expected the run to end");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset with busy inputs
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h5A5B, 1'b1, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b1, "R1");

        // R3 R4 R5 R8: every low-bit base in both orders, with the ignored inputs toggling
        for (int md = 0; md < 2; md++) begin
            for (int lo = 0; lo < 4; lo++) begin
                int b;
                b = 16'h1230 + lo + md * 16'h0400;
                step(1'b1, 1'b0, 1'b0, logic'(md), b, logic'(lo % 2), "R2");
                for (int n = 1; n <= 6; n++)
                    step(1'b1, 1'b0, 1'b1, logic'(1 - md), b ^ 16'h00F3, logic'(1 - lo % 2),
                         (n >= 4) ? "R5" : (md != 0 ? "R4" : "R3"));
            end
        end

        // R6: upper bits hold while base_addr changes
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'hBEEF, 1'b0, "R2");
        for (int n = 0; n < 3; n++)
            step(1'b1, 1'b0, 1'b1, 1'b0, 16'h0100 * n, 1'b0, "R6");

        // R7: a write burst keeps its type while wr_req is low
        step(1'b1, 1'b0, 1'b0, 1'b1, 16'h00C2, 1'b1, "R7");
        for (int n = 0; n < 4; n++)
            step(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, "R7");

        // R8: a mode change in mid-burst has no effect
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0041, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, 1'b1, 16'h0041, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, 1'b1, 16'h0042, 1'b1, "R8");

        // R9: held edges that carry load and advance requests change nothing
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h7777, 1'b1, "R9");
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'h1111, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'h1111, 1'b1, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h2222, 1'b1, "R9");

        // R1: a reset in mid-burst clears the state
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'h3333, 1'b1, "R1");
        step(1'b1, 1'b0, 1'b1, 1'b1, 16'h3333, 1'b1, "R3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule